// File: doc/BRIEF.md
# Circular Fault Event Log Writer

The block turns fault and error reports into fixed 32-byte records and appends them to a circular log in memory. A report carries a kind code, a 16-bit requester ID, an 8-bit type/info byte and a 64-bit faulting address. When logging is running and the log has room, the block packs the record and issues a single write request. The write goes to the log base plus the current tail offset. Once memory acknowledges the write, the tail moves forward by one record, a "new event" status bit is set and a one-cycle interrupt request is raised.

Software programs the base address and a size exponent together, and the log holds 2^size records. Software owns the head pointer and may also rewrite the tail. When the tail has reached the end of the log, a new report sets a sticky overflow bit and raises an interrupt, and nothing is written. While the overflow bit is set, later reports are consumed without writing anything. Only a write-one-to-clear from software removes the overflow bit. Translation and table-read faults also set a target-abort style flag, whether or not logging is running.

Top module: `evlog_writer`

## Requirements
- R1: A record is 256 bits wide. The requester ID sits in bits 15:0, the info byte in bits 62:55 and the 64-bit address in bits 126:63, and all other bits are zero. The record is written at byte address base + tail.
- R2: `sts_running` equals `ctl_global_en & ctl_log_en` one cycle later. A report accepted while it is low is consumed with no write, no tail change and no interrupt.
- R3: When tail >= 32 * 2^size bytes, an accepted report sets `sts_overflow`, pulses `irq` in the following cycle, issues no write and leaves the tail unchanged.
- R4: While `sts_overflow` is set, accepted reports write nothing. After software clears the bit, logging resumes at the current tail.
- R5: The cycle after `mem_valid && mem_ready`, the tail has grown by 32, `sts_new_event` is set and `irq` is high for exactly one cycle.
- R6: `mem_valid`, `mem_addr` and `mem_data` stay stable until `mem_ready`. `ev_ready` is low while a write is outstanding.
- R7: Kind codes 0 (page fault), 1 (page-table read error) and 2 (device-table read error) set `sts_target_abort` even when logging is off. Kind codes 3 (illegal command) and 4 (invalid device-table entry) do not set it.
- R8: `sts_clr` is a write-one-to-clear mask: bit 0 clears overflow, bit 1 clears new-event and bit 2 clears target-abort. A set in the same cycle wins over a clear.
- R9: `head_wr` and `tail_wr` load their pointers with bits 4:0 forced to zero. `cfg_wr` loads base and size together, and the next write uses the new tail.
- R10: After reset, both pointers, all status bits, `irq` and `mem_valid` are zero and `ev_ready` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_global_en | input | 1 | Global unit enable |
| ctl_log_en | input | 1 | Event-log enable |
| cfg_wr | input | 1 | Load base and size |
| cfg_base | input | ADDR_W | Log base byte address |
| cfg_size | input | SIZE_W | Log length exponent, in records |
| head_wr | input | 1 | Load head pointer |
| head_wdata | input | PTR_W | New head byte offset |
| tail_wr | input | 1 | Load tail pointer |
| tail_wdata | input | PTR_W | New tail byte offset |
| sts_clr | input | 3 | Write-one-to-clear mask for status bits |
| ev_valid | input | 1 | Report valid |
| ev_ready | output | 1 | Report accepted when high together with valid |
| ev_kind | input | 3 | Report kind code |
| ev_devid | input | 16 | Requester ID |
| ev_info | input | 8 | Type/info byte |
| ev_addr | input | 64 | Related address |
| mem_valid | output | 1 | Record write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Record byte address |
| mem_data | output | 256 | Packed record |
| head_q | output | PTR_W | Current head offset |
| tail_q | output | PTR_W | Current tail offset |
| sts_overflow | output | 1 | Log overflow (sticky) |
| sts_new_event | output | 1 | A record was written |
| sts_target_abort | output | 1 | Fault-class report seen |
| sts_running | output | 1 | Logging is effective |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Reports are sent under three conditions: with logging disabled, with logging running and room left, and with the log full. The outcomes differ visibly: a silent drop, a write followed by a tail step, or an overflow interrupt with no write. Distinct ID, info and address values in successive records expose swapped or misplaced fields, and the changing write address exposes a wrong tail step. A held-back acknowledge checks that the request stays stable and that the tail commits only after the acknowledge. The full/overflow/clear sequence, a set colliding with a clear, and every kind code separate the sticky and abort rules from ordinary status behaviour.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

    localparam int REC_W     = 256;
    localparam int REC_BYTES = 32;
    localparam int REC_SHIFT = 5;
    localparam int DEVID_W   = 16;
    localparam int INFO_W    = 8;
    localparam int EADDR_W   = 64;
    localparam int INFO_LSB  = 55;
    localparam int EADDR_LSB = 63;

    localparam int ST_OVF   = 0;
    localparam int ST_NEW   = 1;
    localparam int ST_ABORT = 2;
    localparam int ST_N     = 3;

    typedef enum logic [2:0] {
        EV_PAGE_FAULT  = 3'd0,
        EV_PT_READ_ERR = 3'd1,
        EV_DT_READ_ERR = 3'd2,
        EV_ILLEGAL_CMD = 3'd3,
        EV_BAD_DTE     = 3'd4
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e             kind;
        logic [DEVID_W-1:0]   devid;
        logic [INFO_W-1:0]    info;
        logic [EADDR_W-1:0]   addr;
    } ev_req_t;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_e;

    function automatic logic [REC_W-1:0] pack_record(input ev_req_t r);
        logic [REC_W-1:0] rec;
        rec = '0;
        rec[DEVID_W-1:0]            = r.devid;
        rec[INFO_LSB +: INFO_W]     = r.info;
        rec[EADDR_LSB +: EADDR_W]   = r.addr;
        return rec;
    endfunction

    function automatic logic raises_abort(input ev_kind_e k);
        return (k == EV_PAGE_FAULT) || (k == EV_PT_READ_ERR) || (k == EV_DT_READ_ERR);
    endfunction

endpackage

// File: rtl/evlog_ptrs.sv
module evlog_ptrs
    import evlog_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int PTR_W  = 20,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              head_wr,
    input  logic [PTR_W-1:0]  head_wdata,
    input  logic              tail_wr,
    input  logic [PTR_W-1:0]  tail_wdata,
    input  logic              commit,
    output logic [ADDR_W-1:0] base_q,
    output logic [PTR_W-1:0]  head_q,
    output logic [PTR_W-1:0]  tail_q,
    output logic              full
);
    localparam int LEN_W = PTR_W + 1;

    logic [SIZE_W-1:0] size_q;
    logic [LEN_W-1:0]  len_bytes;

    always_comb begin
        len_bytes = LEN_W'(REC_BYTES) << size_q;
        full      = {1'b0, tail_q} >= len_bytes;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            size_q <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (cfg_wr) begin
                base_q <= {cfg_base[ADDR_W-1:REC_SHIFT], {REC_SHIFT{1'b0}}};
                size_q <= cfg_size;
            end
            if (head_wr)
                head_q <= {head_wdata[PTR_W-1:REC_SHIFT], {REC_SHIFT{1'b0}}};
            if (tail_wr)
                tail_q <= {tail_wdata[PTR_W-1:REC_SHIFT], {REC_SHIFT{1'b0}}};
            else if (commit)
                tail_q <= tail_q + PTR_W'(REC_BYTES);
        end
    end

    assert_tail_step_R5: assert property (@(posedge clk) disable iff (rst)
        (commit && !tail_wr) |=> (tail_q == $past(tail_q) + PTR_W'(REC_BYTES)));

    assert_tail_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        tail_q[REC_SHIFT-1:0] == '0);

endmodule

// File: rtl/evlog_status.sv
module evlog_status
    import evlog_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en_global,
    input  logic            en_log,
    input  logic [ST_N-1:0] set,
    input  logic [ST_N-1:0] clr,
    output logic [ST_N-1:0] sts,
    output logic            running
);
    for (genvar i = 0; i < ST_N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                sts[i] <= 1'b0;
            else if (set[i])
                sts[i] <= 1'b1;
            else if (clr[i])
                sts[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            running <= 1'b0;
        else
            running <= en_global & en_log;
    end

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (sts[ST_OVF] && !clr[ST_OVF]) |=> sts[ST_OVF]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set[ST_NEW] |=> sts[ST_NEW]);

    assert_running_mirror_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (running == $past(en_global & en_log)));

endmodule

// File: rtl/evlog_fsm.sv
module evlog_fsm
    import evlog_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int PTR_W  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  ev_req_t           ev,
    input  logic              running,
    input  logic              ovf,
    input  logic              full,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [PTR_W-1:0]  tail_q,
    input  logic              mem_ready,
    output logic              ev_ready,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REC_W-1:0]  mem_data,
    output logic [ST_N-1:0]   sts_set,
    output logic              commit,
    output logic              irq
);
    wr_state_e state;
    logic      accept;
    logic      go_write;
    logic      hit_full;

    always_comb begin
        ev_ready  = (state == WR_IDLE);
        mem_valid = (state == WR_BUSY);
        accept    = ev_valid && ev_ready;
        go_write  = accept && running && !ovf && !full;
        hit_full  = accept && running && !ovf && full;
        commit    = mem_valid && mem_ready;
        sts_set           = '0;
        sts_set[ST_OVF]   = hit_full;
        sts_set[ST_NEW]   = commit;
        sts_set[ST_ABORT] = accept && raises_abort(ev.kind);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WR_IDLE;
            mem_addr <= '0;
            mem_data <= '0;
            irq      <= 1'b0;
        end else begin
            irq <= hit_full || commit;
            if (go_write) begin
                state    <= WR_BUSY;
                mem_addr <= base_q + ADDR_W'(tail_q);
                mem_data <= pack_record(ev);
            end else if (commit) begin
                state <= WR_IDLE;
            end
        end
    end

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    assert_no_accept_inflight_R6: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !ev_ready);

    assert_full_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        hit_full |=> (!mem_valid && irq));

    assert_drop_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && !running) |=> (!mem_valid && !irq));

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

endmodule

// File: rtl/evlog_writer.sv
module evlog_writer
    import evlog_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int PTR_W  = 20,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_global_en,
    input  logic              ctl_log_en,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              head_wr,
    input  logic [PTR_W-1:0]  head_wdata,
    input  logic              tail_wr,
    input  logic [PTR_W-1:0]  tail_wdata,
    input  logic [ST_N-1:0]   sts_clr,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [2:0]        ev_kind,
    input  logic [DEVID_W-1:0] ev_devid,
    input  logic [INFO_W-1:0] ev_info,
    input  logic [EADDR_W-1:0] ev_addr,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REC_W-1:0]  mem_data,
    output logic [PTR_W-1:0]  head_q,
    output logic [PTR_W-1:0]  tail_q,
    output logic              sts_overflow,
    output logic              sts_new_event,
    output logic              sts_target_abort,
    output logic              sts_running,
    output logic              irq
);
    ev_req_t           ev;
    logic [ADDR_W-1:0] base_q;
    logic              full;
    logic              commit;
    logic [ST_N-1:0]   sts_set;
    logic [ST_N-1:0]   sts;

    always_comb begin
        ev.kind  = ev_kind_e'(ev_kind);
        ev.devid = ev_devid;
        ev.info  = ev_info;
        ev.addr  = ev_addr;
        sts_overflow     = sts[ST_OVF];
        sts_new_event    = sts[ST_NEW];
        sts_target_abort = sts[ST_ABORT];
    end

    evlog_ptrs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_base   (cfg_base),
        .cfg_size   (cfg_size),
        .head_wr    (head_wr),
        .head_wdata (head_wdata),
        .tail_wr    (tail_wr),
        .tail_wdata (tail_wdata),
        .commit     (commit),
        .base_q     (base_q),
        .head_q     (head_q),
        .tail_q     (tail_q),
        .full       (full)
    );

    evlog_status u_status (
        .clk       (clk),
        .rst       (rst),
        .en_global (ctl_global_en),
        .en_log    (ctl_log_en),
        .set       (sts_set),
        .clr       (sts_clr),
        .sts       (sts),
        .running   (sts_running)
    );

    evlog_fsm #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev_valid  (ev_valid),
        .ev        (ev),
        .running   (sts_running),
        .ovf       (sts[ST_OVF]),
        .full      (full),
        .base_q    (base_q),
        .tail_q    (tail_q),
        .mem_ready (mem_ready),
        .ev_ready  (ev_ready),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .sts_set   (sts_set),
        .commit    (commit),
        .irq       (irq)
    );

endmodule

// File: tb/evlog_writer_bench.sv
`timescale 1ns/1ps
module evlog_writer_bench;
    localparam int ADDR_W = 48;
    localparam int PTR_W  = 20;
    localparam int SIZE_W = 4;
    localparam logic [ADDR_W-1:0] BASE = 48'h0000_1234_5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_global_en = 0, ctl_log_en = 0, cfg_wr = 0, head_wr = 0, tail_wr = 0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic [PTR_W-1:0]  head_wdata = '0, tail_wdata = '0;
    logic [2:0]        sts_clr = '0;
    logic              ev_valid = 0, mem_ready = 0;
    logic [2:0]        ev_kind = '0;
    logic [15:0]       ev_devid = '0;
    logic [7:0]        ev_info = '0;
    logic [63:0]       ev_addr = '0;
    logic              ev_ready, mem_valid, irq;
    logic [ADDR_W-1:0] mem_addr;
    logic [255:0]      mem_data;
    logic [PTR_W-1:0]  head_q, tail_q;
    logic              sts_overflow, sts_new_event, sts_target_abort, sts_running;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    evlog_writer #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_evlog_writer (
        .clk(clk), .rst(rst), .ctl_global_en(ctl_global_en), .ctl_log_en(ctl_log_en),
        .cfg_wr(cfg_wr), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .head_wr(head_wr), .head_wdata(head_wdata), .tail_wr(tail_wr), .tail_wdata(tail_wdata),
        .sts_clr(sts_clr), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
        .ev_devid(ev_devid), .ev_info(ev_info), .ev_addr(ev_addr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .head_q(head_q), .tail_q(tail_q), .sts_overflow(sts_overflow),
        .sts_new_event(sts_new_event), .sts_target_abort(sts_target_abort),
        .sts_running(sts_running), .irq(irq)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_rec(input logic [15:0] d, input logic [7:0] i,
                                             input logic [63:0] a);
        logic [255:0] r = '0;
        r[15:0]   = d;
        r[62:55]  = i;
        r[126:63] = a;
        return r;
    endfunction

    // Returns at the falling edge after the accepting rising edge.
    task automatic send(input logic [2:0] k, input logic [15:0] d, input logic [7:0] i,
                        input logic [63:0] a);
        @(negedge clk);
        ev_kind = k; ev_devid = d; ev_info = i; ev_addr = a; ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic ack(input logic [2:0] clr);
        mem_ready = 1'b1; sts_clr = clr;
        @(negedge clk);
        mem_ready = 1'b0; sts_clr = '0;
    endtask

    task automatic clear(input logic [2:0] m);
        sts_clr = m;
        @(negedge clk);
        sts_clr = '0;
    endtask

    task automatic load_tail(input logic [PTR_W-1:0] v);
        tail_wr = 1'b1; tail_wdata = v;
        @(negedge clk);
        tail_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 tail", tail_q, 0);
        chk("R10 head", head_q, 0);
        chk("R10 status", {sts_overflow, sts_new_event, sts_target_abort, sts_running}, 0);
        chk("R10 irq/mem_valid", {irq, mem_valid}, 0);
        chk("R10 ev_ready", ev_ready, 1);
    endtask

    task automatic t_disabled();
        send(3'd0, 16'h0042, 8'h01, 64'h1000);
        chk("R2 no write while off", mem_valid, 0);
        chk("R2 no irq while off", irq, 0);
        chk("R2 tail kept while off", tail_q, 0);
        chk("R7 abort set with logging off", sts_target_abort, 1);
        clear(3'b100);
        chk("R8 abort cleared by w1c", sts_target_abort, 0);
        @(negedge clk);
        ctl_global_en = 0; ctl_log_en = 1;
        @(negedge clk);
        chk("R2 log enable alone", sts_running, 0);
        ctl_global_en = 1;
        @(negedge clk);
        chk("R2 both enables", sts_running, 1);
    endtask

    task automatic t_write();
        send(3'd3, 16'hBEEF, 8'hA5, 64'h0123_4567_89AB_CDEF);
        chk("R1 request raised", mem_valid, 1);
        chk("R1 address base+0", mem_addr, BASE);
        chk("R1 record layout", mem_data, exp_rec(16'hBEEF, 8'hA5, 64'h0123_4567_89AB_CDEF));
        chk("R6 ev_ready low in flight", ev_ready, 0);
        chk("R7 kind 3 no abort", sts_target_abort, 0);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk("R6 held valid", mem_valid, 1);
            chk("R6 held data", mem_data, exp_rec(16'hBEEF, 8'hA5, 64'h0123_4567_89AB_CDEF));
            chk("R5 tail waits for ack", tail_q, 0);
        end
        ack(3'b000);
        chk("R5 request dropped", mem_valid, 0);
        chk("R5 tail step", tail_q, 32);
        chk("R5 new event", sts_new_event, 1);
        chk("R5 irq", irq, 1);
        @(negedge clk);
        chk("R5 irq one cycle", irq, 0);
    endtask

    task automatic t_fill();
        send(3'd4, 16'h0001, 8'h11, 64'h40);
        chk("R1 second address", mem_addr, BASE + 48'd32);
        chk("R1 second record", mem_data, exp_rec(16'h0001, 8'h11, 64'h40));
        ack(3'b000);
        chk("R7 kind 4 no abort", sts_target_abort, 0);
        send(3'd1, 16'h0002, 8'h22, 64'hFFFF_0000_0000_1000);
        ack(3'b000);
        chk("R7 kind 1 abort", sts_target_abort, 1);
        send(3'd2, 16'h0003, 8'h33, 64'h80);
        chk("R1 fourth address", mem_addr, BASE + 48'd96);
        ack(3'b000);
        chk("R5 tail at end", tail_q, 128);
        send(3'd3, 16'h0004, 8'h44, 64'hC0);
        chk("R3 no write when full", mem_valid, 0);
        chk("R3 overflow set", sts_overflow, 1);
        chk("R3 irq on full", irq, 1);
        chk("R3 tail unchanged", tail_q, 128);
        @(negedge clk);
        chk("R3 irq one cycle", irq, 0);
    endtask

    task automatic t_sticky();
        load_tail('0);
        chk("R9 tail rewrite", tail_q, 0);
        send(3'd3, 16'h0005, 8'h55, 64'h100);
        chk("R4 no write while overflow", mem_valid, 0);
        chk("R4 no irq while overflow", irq, 0);
        chk("R4 tail kept", tail_q, 0);
        chk("R4 overflow stays", sts_overflow, 1);
        clear(3'b001);
        chk("R8 overflow cleared", sts_overflow, 0);
        clear(3'b010);
        chk("R8 new cleared", sts_new_event, 0);
        send(3'd3, 16'h7777, 8'h66, 64'h200);
        chk("R4 resumes at tail", mem_addr, BASE);
        chk("R4 resume data", mem_data, exp_rec(16'h7777, 8'h66, 64'h200));
        ack(3'b010);
        chk("R8 set beats clear", sts_new_event, 1);
        chk("R5 tail after resume", tail_q, 32);
    endtask

    task automatic t_pointers();
        @(negedge clk);
        head_wr = 1'b1; head_wdata = 20'h2F;
        @(negedge clk);
        head_wr = 1'b0;
        chk("R9 head masked", head_q, 20'h20);
        load_tail(20'h47);
        chk("R9 tail masked", tail_q, 20'h40);
        send(3'd4, 16'h0101, 8'h77, 64'h300);
        chk("R9 write uses new tail", mem_addr, BASE + 48'h40);
        ack(3'b000);
        chk("R9 tail step from loaded", tail_q, 20'h60);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        cfg_wr = 1'b1; cfg_base = BASE; cfg_size = 4'd2;
        @(negedge clk);
        cfg_wr = 1'b0;
        t_write();
        t_fill();
        t_sticky();
        t_pointers();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule